// File: doc/BRIEF.md
# Low-Frequency Reader Clock and Sample Serializer

This block generates every timing signal for a low-frequency inductive reader front end from one master clock, nominally 24 MHz. A programmable divider produces a serial clock. That serial clock is divided again to make the coil drive square wave and the ADC conversion clock. A one-bit select input chooses the carrier: 125 kHz when set and about 136 kHz when clear.

On every conversion the block captures the 8-bit ADC result into a holding register. It then streams that result to a host, most significant bit first, on a serial data line, with a frame strobe that stays high while the bits are on the wire. Data and frame change on the falling edge of the serial clock, so the host can sample them on the rising edge. Because one sample arrives per carrier period, which is eight serial clocks long, back-to-back frames join with no gap.

The serializer is a small machine with three named states. In IDLE no byte is held. In ARMED a byte is held and no frame is active. In SHIFT the frame is active. Its transitions are:
- IDLE to ARMED when a capture occurs.
- ARMED to SHIFT on a serial-clock falling edge.
- SHIFT to SHIFT on a falling edge, either shifting one bit or, after the last bit, reloading a held byte.
- SHIFT to IDLE on the falling edge after the last bit when no byte is held.

Top module: `lf_reader_timing`

## Requirements
- R1: `ser_clk` stays in each level for 11+sel master clocks, where sel is the select value latched at the preceding toggle or at reset. The first rise therefore occurs 11+sel master clocks after reset release.
- R2: `coil_drive` equals bit 2 of the count of `ser_clk` rises since reset, taken modulo 8. This gives a square wave at the serial clock divided by 8, and it changes only in the cycle in which `ser_clk` rises.
- R3: `adc_clk` is identical to `coil_drive` in every cycle, so one conversion is started per carrier period.
- R4: The sample is captured from `adc_data` at the `ser_clk` rise that follows each `adc_clk` rise, which is the 5th, 13th, 21st rise and so on after reset.
- R5: Each captured byte appears on `ser_data` MSB first, one bit per `ser_clk` period. Bit 7 appears at the first falling edge after capture, and `ser_data` changes only in a cycle in which `ser_clk` falls.
- R6: `ser_frame` rises at the first `ser_clk` falling edge after a capture and stays high for exactly 8 serial periods per byte. A byte captured while another is shifting follows it with no gap. The frame changes only when `ser_clk` falls.
- R7: `hf_drive` is always 0.
- R8: `dbg_out` equals `adc_clk` in every cycle.
- R9: A change on `sel_slow` takes effect only at a divider wrap. No `ser_clk` level lasts fewer than 11 or more than 12 master clocks.
- R10: Synchronous reset drives `ser_clk`, `coil_drive`, `adc_clk`, `ser_data` and `ser_frame` low. No frame is produced until the first capture after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_data | input | 8 | ADC conversion result |
| sel_slow | input | 1 | Carrier select: 1 = 125 kHz, 0 = about 136 kHz |
| coil_drive | output | 1 | Coil drive square wave |
| adc_clk | output | 1 | ADC conversion clock |
| ser_clk | output | 1 | Serial clock to host |
| ser_data | output | 1 | Serial sample data, MSB first |
| ser_frame | output | 1 | High while sample bits are shifted |
| hf_drive | output | 1 | Unused high-frequency drive, held low |
| dbg_out | output | 1 | Debug copy of adc_clk |

## Verification
Two events can fall in the same cycle: the falling edge that ends the last bit of one byte, and the reload of the next held byte, which was captured half a serial period earlier while the previous byte was still shifting. Continuous streaming provokes this in every carrier period once the first frame starts. The bench sweeps both carrier settings and several ADC patterns. It requires the frame to stay high across the join and the new byte's MSB to appear exactly eight falls after the previous MSB. A separate sweep toggles the select input at irregular times and judges every serial half-period against the select value present at the preceding toggle.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_ARMED = 2'd1,
        SER_SHIFT = 2'd2
    } ser_state_t;

endpackage

// File: rtl/lfr_divider.sv
module lfr_divider #(
    parameter int BASE_HALF = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_slow,
    output logic ser_clk,
    output logic ser_rise,
    output logic ser_fall
);
    localparam int MAX_HALF = BASE_HALF + 1;
    localparam int CNT_W    = $clog2(MAX_HALF);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;
    logic             sel_q;
    logic             clk_q;
    logic             wrap;

    // terminal count for the half period chosen at the previous wrap
    always_comb begin
        last_cnt = CNT_W'(BASE_HALF - 1) + CNT_W'(sel_q);
        wrap     = (cnt == last_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            sel_q <= sel_slow;
            clk_q <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            sel_q <= sel_slow;
            clk_q <= ~clk_q;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    assign ser_clk  = clk_q;
    assign ser_rise = wrap & ~clk_q;
    assign ser_fall = wrap &  clk_q;

endmodule

// File: rtl/lfr_carrier.sv
module lfr_carrier #(
    parameter int DRIVE_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_rise,
    output logic coil_drive,
    output logic adc_clk,
    output logic capture
);
    localparam int PH_W   = $clog2(DRIVE_DIV);
    localparam int CAP_PH = DRIVE_DIV / 2;

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (ser_rise) begin
            phase <= phase + 1'b1;
        end
    end

    assign coil_drive = phase[PH_W-1];
    assign adc_clk    = phase[PH_W-1];
    // one serial rise after the conversion clock went high
    assign capture    = ser_rise && (phase == PH_W'(CAP_PH));

endmodule

// File: rtl/lfr_serializer.sv
module lfr_serializer
    import lfr_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                capture,
    input  logic                ser_fall,
    input  logic [SAMPLE_W-1:0] adc_data,
    output logic                ser_data,
    output logic                ser_frame
);
    localparam int IDX_W = $clog2(SAMPLE_W);

    ser_state_t          state;
    ser_state_t          nxt;
    logic [SAMPLE_W-1:0] hold;
    logic                hold_valid;
    logic [SAMPLE_W-1:0] shreg;
    logic [IDX_W-1:0]    bit_idx;
    logic                last_bit;
    logic                load;

    always_comb begin
        last_bit = (bit_idx == IDX_W'(SAMPLE_W - 1));
        load     = ser_fall && ((state == SER_ARMED) ||
                                ((state == SER_SHIFT) && last_bit && hold_valid));
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            SER_IDLE:  if (capture)  nxt = SER_ARMED;
            SER_ARMED: if (ser_fall) nxt = SER_SHIFT;
            SER_SHIFT: if (ser_fall && last_bit)
                           nxt = hold_valid ? SER_SHIFT : SER_IDLE;
            default:   nxt = SER_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= SER_IDLE;
        else     state <= nxt;
    end

    // holding register, shifter and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            hold       <= '0;
            hold_valid <= 1'b0;
            shreg      <= '0;
            bit_idx    <= '0;
            ser_frame  <= 1'b0;
        end else begin
            if (load)    hold_valid <= 1'b0;
            if (capture) begin
                hold       <= adc_data;
                hold_valid <= 1'b1;
            end
            if (load) begin
                shreg     <= hold;
                bit_idx   <= '0;
                ser_frame <= 1'b1;
            end else if ((state == SER_SHIFT) && ser_fall) begin
                if (last_bit) begin
                    shreg     <= '0;
                    bit_idx   <= '0;
                    ser_frame <= 1'b0;
                end else begin
                    shreg   <= {shreg[SAMPLE_W-2:0], 1'b0};
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

    assign ser_data = shreg[SAMPLE_W-1];

endmodule

// File: rtl/lf_reader_timing.sv
module lf_reader_timing #(
    parameter int BASE_HALF = 11,
    parameter int DRIVE_DIV = 8,
    parameter int SAMPLE_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] adc_data,
    input  logic                sel_slow,
    output logic                coil_drive,
    output logic                adc_clk,
    output logic                ser_clk,
    output logic                ser_data,
    output logic                ser_frame,
    output logic                hf_drive,
    output logic                dbg_out
);
    logic ser_rise;
    logic ser_fall;
    logic capture;

    lfr_divider #(.BASE_HALF(BASE_HALF)) u_div (
        .clk      (clk),
        .rst      (rst),
        .sel_slow (sel_slow),
        .ser_clk  (ser_clk),
        .ser_rise (ser_rise),
        .ser_fall (ser_fall)
    );

    lfr_carrier #(.DRIVE_DIV(DRIVE_DIV)) u_car (
        .clk        (clk),
        .rst        (rst),
        .ser_rise   (ser_rise),
        .coil_drive (coil_drive),
        .adc_clk    (adc_clk),
        .capture    (capture)
    );

    lfr_serializer #(.SAMPLE_W(SAMPLE_W)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .ser_fall  (ser_fall),
        .adc_data  (adc_data),
        .ser_data  (ser_data),
        .ser_frame (ser_frame)
    );

    assign hf_drive = 1'b0;
    assign dbg_out  = adc_clk;

endmodule

// File: rtl/lfr_checker.sv
module lfr_checker #(
    parameter int BASE = 11
) (
    input logic clk,
    input logic rst,
    input logic coil_drive,
    input logic adc_clk,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_frame,
    input logic hf_drive,
    input logic dbg_out
);
    logic       prev_ser;
    logic [5:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ser <= 1'b0;
            run      <= '0;
        end else begin
            prev_ser <= ser_clk;
            if (ser_clk != prev_ser) run <= 6'd1;
            else if (run != 6'h3f)   run <= run + 1'b1;
        end
    end

    p_half_max_r1: assert property (@(posedge clk) disable iff (rst)
        run <= 6'(BASE + 1));

    p_half_min_r9: assert property (@(posedge clk) disable iff (rst)
        (ser_clk != prev_ser) |-> (run >= 6'(BASE)));

    p_coil_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(coil_drive) |-> $rose(ser_clk));

    p_adc_match_r3: assert property (@(posedge clk) disable iff (rst)
        adc_clk == coil_drive);

    p_data_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(ser_data) |-> $fell(ser_clk));

    p_frame_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(ser_frame) |-> $fell(ser_clk));

    p_hf_low_r7: assert property (@(posedge clk) disable iff (rst)
        hf_drive == 1'b0);

    p_dbg_copy_r8: assert property (@(posedge clk) disable iff (rst)
        dbg_out == adc_clk);

    p_reset_low_r10: assert property (@(posedge clk)
        rst |=> (!ser_clk && !coil_drive && !adc_clk && !ser_data && !ser_frame));

endmodule

bind lf_reader_timing lfr_checker #(.BASE(BASE_HALF)) u_lfr_checker (
    .clk        (clk),
    .rst        (rst),
    .coil_drive (coil_drive),
    .adc_clk    (adc_clk),
    .ser_clk    (ser_clk),
    .ser_data   (ser_data),
    .ser_frame  (ser_frame),
    .hf_drive   (hf_drive),
    .dbg_out    (dbg_out)
);

// File: tb/test_lf_reader_timing.sv
module test_lf_reader_timing;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 11;
    localparam int CFG_CYCLES = 1200;
    localparam int SEL_CYCLES = 3000;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] adc_data = '0;
    logic       sel_slow = 1'b0;
    logic       coil_drive, adc_clk, ser_clk, ser_data, ser_frame, hf_drive, dbg_out;

    int errors = 0;
    int checks = 0;
    int t      = 0;
    int seed   = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lf_reader_timing i_lf_reader_timing (
        .clk        (clk),
        .rst        (rst),
        .adc_data   (adc_data),
        .sel_slow   (sel_slow),
        .coil_drive (coil_drive),
        .adc_clk    (adc_clk),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .ser_frame  (ser_frame),
        .hf_drive   (hf_drive),
        .dbg_out    (dbg_out)
    );

    function automatic logic [7:0] pat(input int x, input int s);
        return 8'((x * s) ^ (x >> 3) ^ (s << 4));
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0d", tag, act, exp, t);
        end
    endtask

    task automatic do_reset(input logic s, input int sd);
        @(negedge clk);
        rst      = 1'b1;
        sel_slow = s;
        seed     = sd;
        adc_data = pat(1, sd);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t   = 0;
        // R10: still in the reset state before the first edge after release
        check("R10 ser_clk", ser_clk, 0);
        check("R10 coil", coil_drive, 0);
        check("R10 adc_clk", adc_clk, 0);
        check("R10 ser_data", ser_data, 0);
        check("R10 ser_frame", ser_frame, 0);
    endtask

    // sweep with fixed select: whole waveform computed from edge count t
    task automatic run_cfg(input logic s, input int sd);
        int h;
        h = BASE + int'(s);
        do_reset(s, sd);
        for (int k = 0; k < CFG_CYCLES; k++) begin
            int q, rises, ph, falls, e_frame, e_data;
            @(posedge clk);
            @(negedge clk);
            t++;
            q     = t / h;
            rises = (q + 1) / 2;
            ph    = rises % 8;
            falls = q / 2;
            e_frame = (falls >= 5) ? 1 : 0;
            e_data  = 0;
            if (e_frame == 1) begin
                int n, b;
                logic [7:0] byt;
                n   = (falls - 5) / 8;
                b   = (falls - 5) % 8;
                // R4: byte taken at rise 5+8n, which is edge h*(2*(5+8n)-1)
                byt = pat(h * (2 * (5 + 8 * n) - 1), sd);
                e_data = int'(byt[7 - b]);
            end
            check("R1 ser_clk", ser_clk, q % 2);
            check("R2 coil", coil_drive, (ph >> 2) & 1);
            check("R3 adc_clk", adc_clk, (ph >> 2) & 1);
            check("R6 frame", ser_frame, e_frame);
            check("R4 R5 ser_data", ser_data, e_data);
            check("R7 hf_drive", hf_drive, 0);
            check("R8 dbg", dbg_out, adc_clk);
            adc_data = pat(t + 1, sd);
        end
    endtask

    // select toggled at irregular times; each level length judged
    task automatic run_sel_sweep();
        int   last_t, exp_len;
        logic prev;
        do_reset(1'b0, 3);
        last_t  = 0;
        exp_len = BASE;
        prev    = 1'b0;
        for (int k = 0; k < SEL_CYCLES; k++) begin
            @(posedge clk);
            @(negedge clk);
            t++;
            if (ser_clk != prev) begin
                check("R9 half period", t - last_t, exp_len);
                exp_len = BASE + int'(sel_slow);
                last_t  = t;
                prev    = ser_clk;
            end
            adc_data = pat(t + 1, 3);
            if (((t * 13) % 29) == 0 || ((t * 7) % 53) == 0) sel_slow = ~sel_slow;
        end
    endtask

    initial begin
        int seeds [4] = '{0, 1, 37, 255};
        for (int si = 0; si < 4; si++) begin
            run_cfg(1'b0, seeds[si]);
            run_cfg(1'b1, seeds[si]);
        end
        run_sel_sweep();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=finished", WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule